// File: doc/BRIEF.md
# Broadcast Multi-Vector Gaussian Scoring Array

This block scores one stream of acoustic model parameters against several buffered speech observation vectors at once. Each lane holds a different observation vector and computes the cost of every model in the stream: for each mixture, a weight plus the sum over coefficients of the squared, variance-scaled distance between the model mean and the observation. The lane then keeps the smallest mixture total. Every model beat is taken once and presented to all lanes in the same cycle. External model bandwidth therefore stays that of a single lane, while throughput grows with the number of lanes. The price is one extra frame of input buffering for each added lane.

A host first writes the per-lane vectors through an indexed load port. It then pulses `start` with the number of models in the batch and streams the models in. One shared controller sequences the coefficient and mixture counters for all lanes. Each lane writes its finished cost into its own result store. The stores advance together and are read out as a single wide word, with lane 0 in the lowest bits. When the merged output is full, the controller stops taking model beats, which stalls every lane together.

Top module: `gauss_bcast_array`

## Requirements
- R1: After reset, `busy`, `res_valid` and `mdl_ready` are all 0.
- R2: For each lane, the cost of a model is the minimum over its M mixtures of (alpha + the sum over k of (((mean_k - x_k) * ivar_k)^2 >> 12)).
  - mean and x are signed 16-bit values.
  - ivar is unsigned 8-bit.
  - alpha is unsigned 32-bit.
  - The cost is a 48-bit unsigned value.
- R3: A model arrives as M*K beats, mixture-major with coefficients in order 0..K-1. alpha is sampled only on the coefficient-0 beat of each mixture; its value on the other beats has no effect.
- R4: Each lane's cost occupies bits [48*i +: 48] of `res_data`. All lane costs of a model appear in the same output beat, and beats come out in model order.
- R5: `mdl_ready` is high only while `busy` is high and fewer than DEPTH results are stored. When the output is full, all lanes stall together and no result is lost.
- R6: A vector write (`vec_we`, `vec_lane`, `vec_idx`, `vec_val`) is ignored while `busy` is high.
- R7: `start` with a nonzero `batch_len` while idle raises `busy` on the next cycle. `busy` falls after the last beat of the `batch_len`-th model. `start` while busy, or with `batch_len` equal to 0, is ignored.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid` stays high and `res_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a batch |
| batch_len | input | BW | Number of models in the batch |
| busy | output | 1 | Batch in progress |
| vec_we | input | 1 | Observation vector write strobe |
| vec_lane | input | LW | Lane selected for the vector write |
| vec_idx | input | KW | Coefficient index for the vector write |
| vec_val | input | XW | Signed coefficient value |
| mdl_valid | input | 1 | Model beat present |
| mdl_ready | output | 1 | Model beat taken this cycle |
| mdl_mean | input | XW | Signed mean coefficient |
| mdl_ivar | input | VW | Unsigned inverse-deviation coefficient |
| mdl_alpha | input | AW | Mixture weight, used on coefficient-0 beats |
| res_valid | output | 1 | Merged result word present |
| res_ready | input | 1 | Consumer accepts the result word |
| res_data | output | LANES*CW | All lane costs of one model, lane 0 lowest |

## Verification
A wrong coefficient or mixture counter shifts which vector coefficient or weight a beat meets. This corrupts every lane's cost at the very first result beat, so each lane is compared against an independently computed cost. A stale or wrongly gated vector register shows up as a mismatch in a single lane. Lost occupancy or pointer state appears during a long output stall: either model beats keep being taken past the store depth, or a result goes missing or repeats once the output drains.

// File: rtl/gauss_bcast_array.sv
module gauss_bcast_array #(
  parameter int LANES = 4,
  parameter int K     = 4,
  parameter int M     = 2,
  parameter int DEPTH = 4,
  parameter int XW    = 16,
  parameter int VW    = 8,
  parameter int AW    = 32,
  parameter int CW    = 48,
  parameter int SHIFT = 12,
  parameter int BW    = 16,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int KW   = (K > 1) ? $clog2(K) : 1,
  localparam int MW   = (M > 1) ? $clog2(M) : 1,
  localparam int PTW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = XW + VW + 2,
  localparam int SW   = 2 * PW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BW-1:0]         batch_len,
  output logic                  busy,
  input  logic                  vec_we,
  input  logic [LW-1:0]         vec_lane,
  input  logic [KW-1:0]         vec_idx,
  input  logic [XW-1:0]         vec_val,
  input  logic                  mdl_valid,
  output logic                  mdl_ready,
  input  logic [XW-1:0]         mdl_mean,
  input  logic [VW-1:0]         mdl_ivar,
  input  logic [AW-1:0]         mdl_alpha,
  output logic                  res_valid,
  input  logic                  res_ready,
  output logic [LANES*CW-1:0]   res_data
);

  logic [KW-1:0]  k_cnt;
  logic [MW-1:0]  m_cnt;
  logic [BW-1:0]  remain;
  logic [PTW:0]   occ;
  logic [PTW-1:0] wp, rp;

  assign mdl_ready = busy && (occ != (PTW+1)'(DEPTH));
  assign res_valid = (occ != '0);

  wire take   = mdl_valid && mdl_ready;
  wire last_k = (k_cnt == KW'(K-1));
  wire last_m = (m_cnt == MW'(M-1));
  wire push   = take && last_k && last_m;
  wire pop    = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
      k_cnt  <= '0;
      m_cnt  <= '0;
    end else if (!busy) begin
      if (start && batch_len != '0) begin
        busy   <= 1'b1;
        remain <= batch_len;
        k_cnt  <= '0;
        m_cnt  <= '0;
      end
    end else if (take) begin
      k_cnt <= last_k ? '0 : k_cnt + 1'b1;
      if (last_k) m_cnt <= last_m ? '0 : m_cnt + 1'b1;
      if (push) begin
        remain <= remain - 1'b1;
        if (remain == BW'(1)) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= '0;
      wp  <= '0;
      rp  <= '0;
    end else begin
      if (push) wp <= (wp == PTW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PTW'(DEPTH-1)) ? '0 : rp + 1'b1;
      occ <= occ + (push ? 1'b1 : 1'b0) - (pop ? 1'b1 : 1'b0);
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [XW-1:0] xv [K];
    logic signed [XW:0]   d;
    logic signed [PW-1:0] p;
    logic signed [SW-1:0] pw;
    logic [SW-1:0]        sq;
    logic [CW-1:0]        term, sum, pick, acc, best;
    logic [CW-1:0]        q [DEPTH];

    assign d    = $signed({mdl_mean[XW-1], mdl_mean}) - $signed({xv[k_cnt][XW-1], xv[k_cnt]});
    assign p    = PW'(d) * PW'($signed({1'b0, mdl_ivar}));
    assign pw   = SW'(p);
    assign sq   = pw * pw;
    assign term = CW'(sq >> SHIFT);
    assign sum  = ((k_cnt == '0) ? CW'(mdl_alpha) : acc) + term;
    assign pick = (m_cnt == '0 || sum < best) ? sum : best;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int i = 0; i < K; i++) xv[i] <= '0;
        acc  <= '0;
        best <= '0;
      end else begin
        if (vec_we && !busy && vec_lane == LW'(g)) xv[vec_idx] <= vec_val;
        if (take) begin
          acc <= sum;
          if (last_k) best <= pick;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (push) q[wp] <= pick;
    end

    assign res_data[g*CW +: CW] = q[rp];
  end

endmodule

module gauss_bcast_chk #(
  parameter int DEPTH = 4,
  parameter int OW    = 8,
  parameter int BW    = 16,
  parameter int OCW   = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [BW-1:0]  batch_len,
  input logic           busy,
  input logic           mdl_ready,
  input logic           res_valid,
  input logic           res_ready,
  input logic [OW-1:0]  res_data,
  input logic [OCW-1:0] occ
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) occ <= OCW'(DEPTH)); // R5
  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) mdl_ready |-> busy); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data)); // R8
  AST_START_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && batch_len != '0 |=> busy); // R7
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (!start || batch_len == '0) |=> !busy); // R7
endmodule

bind gauss_bcast_array gauss_bcast_chk #(
  .DEPTH(DEPTH), .OW(LANES*CW), .BW(BW), .OCW(PTW+1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .batch_len(batch_len), .busy(busy),
  .mdl_ready(mdl_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .occ(occ)
);

// File: tb/sim_gauss_bcast_array.sv
module sim_gauss_bcast_array;
  localparam int LANES = 4, K = 4, M = 2, DEPTH = 4, CW = 48;

  logic clk = 0, rst_n = 0;
  logic start = 0, vec_we = 0, mdl_valid = 0, res_ready = 0;
  logic [15:0] batch_len = 0;
  logic [1:0]  vec_lane = 0, vec_idx = 0;
  logic [15:0] vec_val = 0, mdl_mean = 0;
  logic [7:0]  mdl_ivar = 0;
  logic [31:0] mdl_alpha = 0;
  logic busy, mdl_ready, res_valid;
  logic [LANES*CW-1:0] res_data;

  gauss_bcast_array u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, got = 0, rdy_mode = 0;
  bit done = 0;
  logic [LANES*CW-1:0] expq [$];
  int xb [LANES][K];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    res_ready = (rdy_mode == 1) ? 1'($urandom_range(0, 1)) : (rdy_mode == 2);
    if (res_valid && res_ready) begin
      got++;
      if (expq.size() == 0) chk(0, "R4 unexpected result", 64'(got), 0);
      else begin
        logic [LANES*CW-1:0] e;
        e = expq.pop_front();
        for (int l = 0; l < LANES; l++)
          chk(res_data[l*CW +: CW] == e[l*CW +: CW], $sformatf("R2/R4 lane %0d", l),
              64'(res_data[l*CW +: CW]), 64'(e[l*CW +: CW]));
      end
    end
  end

  task automatic load(input int lane, input int idx, input int val, input bit track);
    @(negedge clk);
    vec_we = 1; vec_lane = 2'(lane); vec_idx = 2'(idx); vec_val = 16'(val);
    @(negedge clk);
    vec_we = 0;
    if (track) xb[lane][idx] = int'($signed(16'(val)));
  endtask

  task automatic start_batch(input int n);
    @(negedge clk);
    start = 1; batch_len = 16'(n);
    @(negedge clk);
    start = 0;
  endtask

  task automatic run_model();
    logic signed [15:0] mn [M][K];
    logic [7:0] iv [M][K];
    logic [31:0] al [M];
    logic [LANES*CW-1:0] e;
    for (int m = 0; m < M; m++) begin
      al[m] = $urandom;
      for (int k = 0; k < K; k++) begin
        mn[m][k] = 16'($urandom);
        iv[m][k] = 8'($urandom);
      end
    end
    for (int l = 0; l < LANES; l++) begin
      longint best = 0;
      for (int m = 0; m < M; m++) begin
        longint s = longint'(al[m]);
        for (int k = 0; k < K; k++) begin
          longint dd = longint'(mn[m][k]) - longint'(xb[l][k]);
          longint pp = dd * longint'(iv[m][k]);
          s += (pp * pp) >>> 12;
        end
        if (m == 0 || s < best) best = s;
      end
      e[l*CW +: CW] = best[CW-1:0];
    end
    expq.push_back(e);
    for (int m = 0; m < M; m++)
      for (int k = 0; k < K; k++) begin
        mdl_valid = 1; mdl_mean = mn[m][k]; mdl_ivar = iv[m][k];
        mdl_alpha = (k == 0) ? al[m] : $urandom;  // R3: non-zero beats carry noise
        while (!mdl_ready) @(negedge clk);
        @(negedge clk);
      end
    mdl_valid = 0;
  endtask

  task automatic wait_drain(input int n);
    for (int i = 0; i < 2000 && got < n; i++) @(negedge clk);
    chk(got == n, "R4 result count", 64'(got), 64'(n));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0, "R1 busy", 64'(busy), 0);
    chk(res_valid == 0, "R1 res_valid", 64'(res_valid), 0);
    chk(mdl_ready == 0, "R1 mdl_ready", 64'(mdl_ready), 0);
    rst_n = 1;
    @(negedge clk);
    for (int l = 0; l < LANES; l++)
      for (int k = 0; k < K; k++) load(l, k, int'($urandom_range(0, 65535)), 1);

    // R7: zero-length start ignored
    start_batch(0);
    chk(busy == 0, "R7 zero batch_len", 64'(busy), 0);

    // batch 1: random readiness, loads and restart while busy
    rdy_mode = 1;
    @(negedge clk);
    start = 1; batch_len = 5;
    @(negedge clk);
    start = 0;
    chk(busy == 1, "R7 busy rise", 64'(busy), 1);
    fork
      for (int i = 0; i < 5; i++) run_model();
      begin
        repeat (6) @(negedge clk);
        load(0, 0, 16'h7123, 0);   // R6: ignored while busy
        load(3, 2, 16'h8001, 0);
        start_batch(9);            // R7: ignored while busy
      end
    join
    @(negedge clk);
    chk(busy == 0, "R7 busy fall", 64'(busy), 0);
    chk(mdl_ready == 0, "R5 ready low when idle", 64'(mdl_ready), 0);
    wait_drain(5);

    // batch 2: output stall fills the store, all lanes halt (R5, R8)
    rdy_mode = 0;
    start_batch(6);
    fork
      for (int i = 0; i < 6; i++) run_model();
      begin
        logic [LANES*CW-1:0] held;
        repeat (80) @(negedge clk);
        chk(mdl_ready == 0, "R5 stall when full", 64'(mdl_ready), 0);
        chk(busy == 1, "R5 batch held", 64'(busy), 1);
        held = res_data;
        repeat (5) @(negedge clk);
        chk(res_valid == 1, "R8 valid held", 64'(res_valid), 1);
        chk(res_data == held, "R8 data held", 64'(res_data[63:0]), 64'(held[63:0]));
        rdy_mode = 1;
      end
    join
    wait_drain(11);

    // batch 3: legal reload while idle, always-ready output
    load(1, 3, 16'h8000, 1);
    load(2, 0, 16'h7FFF, 1);
    rdy_mode = 2;
    start_batch(3);
    for (int i = 0; i < 3; i++) run_model();
    wait_drain(14);
    chk(expq.size() == 0, "R4 queue empty", 64'(expq.size()), 0);
    finish_run();
  end
endmodule